// File: doc/BRIEF.md
# Power-Fail Write-Protect Controller

This block decides, from three digitised supply comparator flags, when a byte-wide battery-backed memory must be cut off from its host. While the supply is healthy the memory is open for access. Once the supply sinks into the band between the two deselect thresholds, or below the lower one, the block raises a write-protect/deselect signal. The memory then treats all address and control inputs as ignored and floats its data pins. When the supply falls further, past the switchover level, the block also selects the battery as the memory's supply path. On power-up it keeps the memory protected for a programmable hold-off time after the supply has settled above the upper threshold. Only then does it report the memory as ready.

Each comparator flag enters through a two-stage synchroniser and a run-length filter, so a supply spike shorter than the filter length cannot move the mode. The mode logic is a four-state machine. NORMAL means the memory is open. PROTECTED means the supply is below or inside the window with the battery not yet in use. BATTERY means the supply is below the switchover level. RECOVER means the supply is good and the hold-off timer is running. The transitions are:
- Reset → PROTECTED.
- NORMAL → PROTECTED when the supply leaves the good range.
- Any state → BATTERY when the switchover flag is set.
- BATTERY → PROTECTED when the switchover flag clears.
- PROTECTED → RECOVER when the supply is good.
- RECOVER → PROTECTED when the supply leaves the good range during hold-off; the timer restarts.
- RECOVER → NORMAL when the timer completes.

The hold-off count, in clock cycles, is a parameter. At a 200 MHz clock the default corresponds to 40 ms.

Top module: `pfail_guard`

## Requirements
- R1: While reset is asserted and right after it, the block is in PROTECTED: `wp_o`=1, `bat_sel_o`=0, `ready_o`=0.
- R2: A flag level reaches the mode logic only after two synchroniser stages and FILT_LEN consecutive agreeing samples. A level held at the input for fewer than FILT_LEN cycles never changes the mode. A level held long enough changes the outputs after the (FILT_LEN+3)-th rising clock edge following the input change.
- R3: In NORMAL, a qualified upper-threshold flag of 0 or a qualified lower-threshold flag of 1 moves the block to PROTECTED.
- R4: In PROTECTED, with upper flag 1, lower flag 0 and switchover flag 0, the block enters RECOVER. It stays there exactly REC_CYC cycles and then enters NORMAL.
- R5: In RECOVER, an upper flag of 0 or a lower flag of 1 returns the block to PROTECTED. A later recovery counts the full REC_CYC cycles again.
- R6: A qualified switchover flag of 1 moves any state to BATTERY. This check has priority over every other transition. In BATTERY, a switchover flag of 0 moves the block to PROTECTED.
- R7: `wp_o` is 1 in every state except NORMAL. `bat_sel_o` is 1 only in BATTERY. `ready_o` is 1 only in NORMAL.
- R8: NORMAL is entered only from RECOVER, and only in the cycle after the hold-off counter reports completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_above_hi | input | 1 | Comparator: supply above upper deselect threshold (asynchronous) |
| sup_below_lo | input | 1 | Comparator: supply below lower deselect threshold (asynchronous) |
| sup_below_sw | input | 1 | Comparator: supply below battery switchover level (asynchronous) |
| wp_o | output | 1 | Memory deselect / write-protect, 1 = protected |
| bat_sel_o | output | 1 | 1 = memory supplied from battery |
| ready_o | output | 1 | 1 = memory open for normal access |

## Verification
The assertions check on every cycle the following:
- NORMAL is reached only through a completed hold-off (R8).
- A qualified low-supply or switchover flag forces the machine out of NORMAL or into BATTERY on the next edge.
- The hold-off counter stays within its limit and clears outside RECOVER.
- A filter output changes only to the synchronised value.

Only the bench's scenarios can show the following:
- The exact qualification latency.
- The rejection of spikes one cycle shorter than the filter.
- The full hold-off length.
- The restart of the hold-off after a dip.

The bench exercises these directed and under a random supply walk, comparing against a cycle model.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
    typedef enum logic [1:0] {
        ST_PROT    = 2'd0,
        ST_BATT    = 2'd1,
        ST_RECOVER = 2'd2,
        ST_NORMAL  = 2'd3
    } pfg_state_e;

    localparam int FLAG_HI  = 0;
    localparam int FLAG_LO  = 1;
    localparam int FLAG_SW  = 2;
    localparam int NUM_FLAG = 3;
endpackage

// File: rtl/pfg_flag_qual.sv
module pfg_flag_qual #(
    parameter int FILT_LEN = 3,
    parameter bit RST_VAL  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic qual_o
);
    localparam int FW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

    logic          sync_a, sync_b;
    logic [FW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= RST_VAL;
            sync_b <= RST_VAL;
        end else begin
            sync_a <= raw_i;
            sync_b <= sync_a;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_o  <= RST_VAL;
            run_cnt <= '0;
        end else if (sync_b == qual_o) begin
            run_cnt <= '0;
        end else if (run_cnt == FW'(FILT_LEN - 1)) begin
            qual_o  <= sync_b;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R2
    qual_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(qual_o) |-> (qual_o == $past(sync_b)));
endmodule

// File: rtl/pfg_holdoff.sv
module pfg_holdoff #(
    parameter int REC_CYC = 8_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (REC_CYC > 1) ? $clog2(REC_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(REC_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run_i)       cnt <= '0;
        else if (cnt != LAST)  cnt <= cnt + 1'b1;
    end

    assign done_o = run_i && (cnt == LAST);

    // R4
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt == '0));
endmodule

// File: rtl/pfg_mode_fsm.sv
module pfg_mode_fsm
    import pfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hi_q,
    input  logic lo_q,
    input  logic sw_q,
    input  logic hold_done,
    output logic hold_run,
    output logic wp_o,
    output logic bat_sel_o,
    output logic ready_o
);
    pfg_state_e state, state_nx;
    logic       supply_good;

    assign supply_good = hi_q && !lo_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_NORMAL: begin
                if (sw_q)              state_nx = ST_BATT;
                else if (!supply_good) state_nx = ST_PROT;
            end
            ST_PROT: begin
                if (sw_q)              state_nx = ST_BATT;
                else if (supply_good)  state_nx = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (sw_q)              state_nx = ST_BATT;
                else if (!supply_good) state_nx = ST_PROT;
                else if (hold_done)    state_nx = ST_NORMAL;
            end
            ST_BATT: begin
                if (!sw_q)             state_nx = ST_PROT;
            end
            default:                   state_nx = ST_PROT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PROT;
        else        state <= state_nx;
    end

    always_comb begin
        wp_o      = 1'b1;
        bat_sel_o = 1'b0;
        ready_o   = 1'b0;
        hold_run  = 1'b0;
        unique case (state)
            ST_NORMAL:  begin wp_o = 1'b0; ready_o = 1'b1; end
            ST_BATT:    bat_sel_o = 1'b1;
            ST_RECOVER: hold_run = 1'b1;
            default:    ;
        endcase
    end

    // R8
    normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(hold_done) && $past(state) == ST_RECOVER));
    // R3
    normal_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && (lo_q || !hi_q)) |=> (state != ST_NORMAL));
    // R6
    batt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_q |=> (state == ST_BATT));
    // R6
    batt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BATT && !sw_q) |=> (state == ST_PROT));
endmodule

// File: rtl/pfail_guard.sv
module pfail_guard
    import pfg_pkg::*;
#(
    parameter int FILT_LEN = 3,
    parameter int REC_CYC  = 8_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_above_hi,
    input  logic sup_below_lo,
    input  logic sup_below_sw,
    output logic wp_o,
    output logic bat_sel_o,
    output logic ready_o
);
    localparam logic [NUM_FLAG-1:0] FLAG_RST = 3'b010;

    logic [NUM_FLAG-1:0] raw_flags, qual_flags;
    logic                hold_run, hold_done;

    assign raw_flags = {sup_below_sw, sup_below_lo, sup_above_hi};

    for (genvar g = 0; g < NUM_FLAG; g++) begin : g_qual
        pfg_flag_qual #(
            .FILT_LEN (FILT_LEN),
            .RST_VAL  (FLAG_RST[g])
        ) u_qual (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_flags[g]),
            .qual_o (qual_flags[g])
        );
    end

    pfg_holdoff #(.REC_CYC(REC_CYC)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (hold_run),
        .done_o (hold_done)
    );

    pfg_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_q      (qual_flags[FLAG_HI]),
        .lo_q      (qual_flags[FLAG_LO]),
        .sw_q      (qual_flags[FLAG_SW]),
        .hold_done (hold_done),
        .hold_run  (hold_run),
        .wp_o      (wp_o),
        .bat_sel_o (bat_sel_o),
        .ready_o   (ready_o)
    );
endmodule

// File: tb/sim_pfail_guard.sv
`timescale 1ns/1ps
module sim_pfail_guard;
    localparam int FL  = 3;
    localparam int REC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi = 1'b0, lo = 1'b1, sw = 1'b1;
    logic wp, bsel, rdy;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    string tag = "R7";

    always #2.5 clk = ~clk;

    pfail_guard #(.FILT_LEN(FL), .REC_CYC(REC)) u0 (
        .clk(clk), .rst_n(rst_n),
        .sup_above_hi(hi), .sup_below_lo(lo), .sup_below_sw(sw),
        .wp_o(wp), .bat_sel_o(bsel), .ready_o(rdy)
    );

    // Cycle model built from the requirements: 0=PROT 1=BATT 2=RECOVER 3=NORMAL
    logic [2:0] m_a, m_b, m_q;
    int         m_run[3];
    int         m_st, m_tc;

    function automatic logic [2:0] exp_outs(int st);
        // {wp, bsel, ready}
        case (st)
            3:       return 3'b001;
            1:       return 3'b110;
            default: return 3'b100;
        endcase
    endfunction

    task automatic model_reset();
        m_a = 3'b010; m_b = 3'b010; m_q = 3'b010;
        for (int i = 0; i < 3; i++) m_run[i] = 0;
        m_st = 0; m_tc = 0;
    endtask

    task automatic model_step(logic [2:0] in);
        logic [2:0] nq;
        int nst, ntc;
        logic good, done;
        good = m_q[0] && !m_q[1];
        done = (m_st == 2) && (m_tc == REC - 1);
        nst = m_st;
        if (m_q[2]) nst = 1;
        else case (m_st)
            3: if (!good) nst = 0;
            0: if (good) nst = 2;
            2: if (!good) nst = 0; else if (done) nst = 3;
            1: nst = 0;
            default: nst = 0;
        endcase
        ntc = (m_st != 2) ? 0 : ((m_tc < REC - 1) ? m_tc + 1 : m_tc);
        nq = m_q;
        for (int i = 0; i < 3; i++) begin
            if (m_b[i] == m_q[i]) m_run[i] = 0;
            else if (m_run[i] == FL - 1) begin nq[i] = m_b[i]; m_run[i] = 0; end
            else m_run[i]++;
        end
        m_q = nq; m_b = m_a; m_a = in; m_st = nst; m_tc = ntc;
    endtask

    task automatic check(string req, logic [2:0] act, logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {wp,bat_sel,ready} actual=%b expected=%b at %0t",
                     req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step({sw, lo, hi});
        #1;
        check(tag, {wp, bsel, rdy}, exp_outs(m_st));
    endtask

    task automatic drive(int volt);
        hi = (volt >= 50);
        lo = (volt < 45);
        sw = (volt < 30);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        int cnt;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(posedge clk);
        #1;
        tag = "R1";
        check("R1", {wp, bsel, rdy}, 3'b100);
        rst_n = 1'b1;
        cyc();
        check("R1", {wp, bsel, rdy}, 3'b100);

        // R6: low supply reaches battery mode
        tag = "R6";
        run(10);
        check("R6", {wp, bsel, rdy}, 3'b110);

        // R6/R4: supply back inside window then good
        drive(47); run(10);
        check("R6", {wp, bsel, rdy}, 3'b100);
        tag = "R4";
        drive(80);
        cnt = 0;
        while (!rdy && cnt < 100) begin cyc(); cnt++; end
        n_chk++;
        if (cnt != FL + 3 + REC) begin
            n_bad++;
            $display("FAIL R4: cycles to ready actual=%0d expected=%0d", cnt, FL + 3 + REC);
        end

        // R2: spike one cycle shorter than the filter is ignored
        tag = "R2";
        drive(48); run(FL - 1); drive(80); run(12);
        check("R2", {wp, bsel, rdy}, 3'b001);

        // R3/R2: dip lasting FL cycles drops ready on edge FL+3
        tag = "R3";
        drive(48);
        run(FL + 2);
        check("R2", {wp, bsel, rdy}, 3'b001);
        drive(80);
        cyc();
        check("R3", {wp, bsel, rdy}, 3'b100);

        // R5: dip during hold-off restarts the count
        tag = "R5";
        run(12);
        drive(48); run(FL); drive(80);
        cnt = 0;
        while (!rdy && cnt < 200) begin cyc(); cnt++; end
        n_chk++;
        if (cnt <= REC) begin
            n_bad++;
            $display("FAIL R5: cycles to ready actual=%0d expected>%0d", cnt, REC);
        end

        // R3: lower flag in NORMAL with upper still set
        tag = "R3";
        hi = 1'b1; lo = 1'b1; sw = 1'b0;
        run(FL + 3);
        check("R3", {wp, bsel, rdy}, 3'b100);

        // R6 priority: switchover with other flags good
        tag = "R6";
        hi = 1'b1; lo = 1'b0; sw = 1'b1;
        run(FL + 3);
        check("R6", {wp, bsel, rdy}, 3'b110);

        // R7/R8: random supply walk against the model
        tag = "R7";
        begin
            int v = 60;
            for (int seg = 0; seg < 300; seg++) begin
                if ($urandom_range(0, 5) == 0) begin
                    drive($urandom_range(0, 100));
                    run($urandom_range(1, FL - 1));
                end
                v = v + $urandom_range(0, 40) - 20;
                if (v < 0) v = 0;
                if (v > 100) v = 100;
                drive(v);
                run($urandom_range(1, 45));
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule